// File: doc/BRIEF.md
# Eight-Point Radix-2 FFT Engine With External Twiddle Source

This block computes an 8-point forward discrete Fourier transform over signed fixed-point complex samples, using three radix-2 decimation-in-time butterfly stages that run one after another on a single butterfly datapath. A frame of eight complex samples enters through a valid/ready port. Each sample is stored at the bit-reversed position of its arrival index, so the spectrum comes out in natural order with no reordering after the transform.

The engine keeps no table of twiddle factors. Before each butterfly it raises a request carrying a twiddle angle in whole degrees and waits, as long as needed, for a cosine/sine pair supplied by an external rotation unit. Each stage halves its results and clips them to the sample width. The eight bins then leave through a valid/ready output port, and a done flag marks the last bin. A new frame is taken only after the last bin has been taken.

Top module: `fft8_core`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid`, `tw_req_valid` and `out_done` are 0.
- R2: A frame is exactly 8 samples, each taken on a cycle with `in_valid` and `in_ready` high. `in_ready` stays low from the cycle after the 8th sample until the cycle after the 8th output has been taken, and is then high again.
- R3: One twiddle request is made per butterfly, 12 per frame, with angles in degrees in this order: 0,0,0,0 / 0,90,0,90 / 0,45,90,135. In stage s (0 to 2) butterfly b uses exponent (b mod 2^s)·2^(2−s) and angle 45 times that exponent. While `tw_req_valid` is high and `tw_rsp_valid` is low, the request and its angle hold, and the transform does not advance.
- R4: Sample n of the frame is stored at the bit-reversed index of n. In stage s, butterfly b combines entries a = (b div 2^s)·2^(s+1) + (b mod 2^s) and a + 2^s. A twiddle reply (c, s) has 6 fraction bits (64 means 1.0) and stands for W = c − j·s. The product is t_re = floor((b_re·c + b_im·s)/64) and t_im = floor((b_im·c − b_re·s)/64).
- R5: Each butterfly writes floor((a + t)/2) to the upper entry and floor((a − t)/2) to the lower entry, per component, clipped to the range −128 to 127.
- R6: Output bins leave in order k = 0..7, one on each cycle with `out_valid` and `out_ready` high. While `out_ready` is low, `out_valid` and the data hold.
- R7: `out_done` is high only while bin 7 is presented.
- R8: `in_valid` while `in_ready` is low has no effect on any output of the frame in progress or on the next frame.
- R9: `tw_rsp_valid` while no request is pending has no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Engine accepts an input sample |
| in_re | input | 8 | Input real part, signed |
| in_im | input | 8 | Input imaginary part, signed |
| tw_req_valid | output | 1 | Twiddle request pending |
| tw_angle | output | 9 | Requested twiddle angle in degrees |
| tw_rsp_valid | input | 1 | Twiddle reply present |
| tw_cos | input | 8 | Cosine of the requested angle, signed, 6 fraction bits |
| tw_sin | input | 8 | Sine of the requested angle, signed, 6 fraction bits |
| out_valid | output | 1 | Output bin presented |
| out_ready | input | 1 | Consumer takes the output bin |
| out_re | output | 8 | Output bin real part, signed |
| out_im | output | 8 | Output bin imaginary part, signed |
| out_done | output | 1 | Presented bin is the last of the frame |

## Verification
With correct twiddles, the per-stage halving keeps almost every frame inside the sample range, so the clipping of R5 is very hard to reach through the data port alone. The bench therefore plays the rotation unit and, for some frames, replies with inflated values (magnitudes near 2.0, or negative full scale). This drives the stage sums past the rail in several butterflies, and the reference model predicts every clipped bin. The same responder varies its reply latency and sends stray replies while no request is pending. The input side keeps offering junk samples during the whole transform and output phase, which exercises R8 and R9 together with backpressure on the output.

// File: rtl/fft8_pkg.sv
package fft8_pkg;

  // Engine phases: take samples, wait for a twiddle, run a butterfly, emit bins
  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_TWID = 2'd1,
    ST_BFLY = 2'd2,
    ST_EMIT = 2'd3
  } fft_state_e;

  // Reverse the low nb bits of v
  function automatic int unsigned bit_rev(input int unsigned v, input int unsigned nb);
    int unsigned r;
    r = 0;
    for (int unsigned i = 0; i < nb; i++) begin
      r = r | (((v >> i) & 32'd1) << (nb - 1 - i));
    end
    return r;
  endfunction

endpackage

// File: rtl/fft8_mul.sv
// Signed multiplier built from four half-width unsigned sub-products.
module fft8_mul #(
  parameter int W = 8
) (
  input  logic signed [W-1:0]   a,
  input  logic signed [W-1:0]   b,
  output logic signed [2*W-1:0] p
);
  localparam int H  = W / 2;
  localparam int PW = 2 * W;

  logic [W-1:0]  mag_a, mag_b;
  logic [PW-1:0] mag_p;
  logic          neg;
  logic [2*H-1:0] part [4];

  always_comb begin
    mag_a = a[W-1] ? W'(~a + W'(1)) : W'(a);
    mag_b = b[W-1] ? W'(~b + W'(1)) : W'(b);
    neg   = a[W-1] ^ b[W-1];
  end

  // part[g]: g[1] picks the half of a, g[0] the half of b
  for (genvar g = 0; g < 4; g++) begin : g_part
    assign part[g] = {{H{1'b0}}, mag_a[(g / 2) * H +: H]} *
                     {{H{1'b0}}, mag_b[(g % 2) * H +: H]};
  end

  always_comb begin
    mag_p = '0;
    for (int g = 0; g < 4; g++) begin
      mag_p = mag_p + (PW'(part[g]) << (((g / 2) + (g % 2)) * H));
    end
    p = neg ? $signed(PW'(~mag_p + PW'(1))) : $signed(mag_p);
  end

endmodule

// File: rtl/fft8_bfly.sv
// One radix-2 butterfly: t = W*b with W = c - j*s, outputs (a +/- t)/2, clipped.
module fft8_bfly #(
  parameter int DW = 8,
  parameter int TW = 8
) (
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [TW-1:0] w_cos,
  input  logic signed [TW-1:0] w_sin,
  output logic signed [DW-1:0] y0_re,
  output logic signed [DW-1:0] y0_im,
  output logic signed [DW-1:0] y1_re,
  output logic signed [DW-1:0] y1_im
);
  localparam int MW   = (DW > TW) ? DW : TW;
  localparam int FRAC = TW - 2;
  localparam int PW   = 2 * MW + 1;
  localparam int SW   = PW + 1;
  localparam logic signed [SW-1:0] HI = SW'((1 <<< (DW - 1)) - 1);
  localparam logic signed [SW-1:0] LO = SW'(-(1 <<< (DW - 1)));

  logic signed [MW-1:0]   op_x [4];
  logic signed [MW-1:0]   op_y [4];
  logic signed [2*MW-1:0] prod [4];
  logic signed [PW-1:0]   t_re, t_im;
  logic signed [SW-1:0]   s_hi_re, s_hi_im, s_lo_re, s_lo_im;

  always_comb begin
    op_x[0] = MW'(b_re);  op_y[0] = MW'(w_cos);
    op_x[1] = MW'(b_im);  op_y[1] = MW'(w_sin);
    op_x[2] = MW'(b_im);  op_y[2] = MW'(w_cos);
    op_x[3] = MW'(b_re);  op_y[3] = MW'(w_sin);
  end

  for (genvar m = 0; m < 4; m++) begin : g_mul
    fft8_mul #(.W(MW)) u_mul (
      .a (op_x[m]),
      .b (op_y[m]),
      .p (prod[m])
    );
  end

  function automatic logic signed [DW-1:0] clip(input logic signed [SW-1:0] v);
    if (v > HI)      return HI[DW-1:0];
    else if (v < LO) return LO[DW-1:0];
    else             return v[DW-1:0];
  endfunction

  always_comb begin
    t_re    = (PW'(prod[0]) + PW'(prod[1])) >>> FRAC;
    t_im    = (PW'(prod[2]) - PW'(prod[3])) >>> FRAC;
    s_hi_re = (SW'(a_re) + SW'(t_re)) >>> 1;
    s_hi_im = (SW'(a_im) + SW'(t_im)) >>> 1;
    s_lo_re = (SW'(a_re) - SW'(t_re)) >>> 1;
    s_lo_im = (SW'(a_im) - SW'(t_im)) >>> 1;
    y0_re   = clip(s_hi_re);
    y0_im   = clip(s_hi_im);
    y1_re   = clip(s_lo_re);
    y1_im   = clip(s_lo_im);
  end

endmodule

// File: rtl/fft8_core.sv
module fft8_core
  import fft8_pkg::*;
#(
  parameter int NPTS = 8,
  parameter int DW   = 8,
  parameter int TW   = 8,
  parameter int AW   = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 tw_req_valid,
  output logic [AW-1:0]        tw_angle,
  input  logic                 tw_rsp_valid,
  input  logic signed [TW-1:0] tw_cos,
  input  logic signed [TW-1:0] tw_sin,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im,
  output logic                 out_done
);
  localparam int LGN  = $clog2(NPTS);
  localparam int NBF  = NPTS / 2;
  localparam int STW  = (LGN > 1) ? $clog2(LGN) : 1;
  localparam int BIW  = (LGN > 1) ? LGN - 1 : 1;
  localparam int DEG  = 360 / NPTS;
  localparam logic [LGN-1:0] LAST_SMP = LGN'(NPTS - 1);
  localparam logic [BIW-1:0] LAST_BF  = BIW'(NBF - 1);
  localparam logic [STW-1:0] LAST_ST  = STW'(LGN - 1);

  fft_state_e           state;
  logic [LGN-1:0]       cnt;
  logic [STW-1:0]       stg;
  logic [BIW-1:0]       bfi;
  logic signed [TW-1:0] w_c, w_s;
  logic signed [DW-1:0] mem_re [NPTS];
  logic signed [DW-1:0] mem_im [NPTS];

  logic [LGN-1:0]       idx_a, idx_b, load_addr;
  logic [AW-1:0]        angle;
  logic signed [DW-1:0] y0_re, y0_im, y1_re, y1_im;

  // Butterfly addressing and twiddle angle for the current stage/butterfly
  always_comb begin
    int unsigned span, jj, grp, base, ex;
    span      = 32'd1 << stg;
    jj        = 32'(bfi) & (span - 1);
    grp       = 32'(bfi) >> stg;
    base      = (grp << (32'(stg) + 1)) | jj;
    ex        = jj << (LGN - 1 - 32'(stg));
    idx_a     = LGN'(base);
    idx_b     = LGN'(base + span);
    angle     = AW'(ex * DEG);
    load_addr = LGN'(bit_rev(32'(cnt), LGN));
  end

  fft8_bfly #(.DW(DW), .TW(TW)) u_bfly (
    .a_re  (mem_re[idx_a]),
    .a_im  (mem_im[idx_a]),
    .b_re  (mem_re[idx_b]),
    .b_im  (mem_im[idx_b]),
    .w_cos (w_c),
    .w_sin (w_s),
    .y0_re (y0_re),
    .y0_im (y0_im),
    .y1_re (y1_re),
    .y1_im (y1_im)
  );

  // Control sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_LOAD;
      cnt   <= '0;
      stg   <= '0;
      bfi   <= '0;
      w_c   <= '0;
      w_s   <= '0;
    end else begin
      case (state)
        ST_LOAD: begin
          if (in_valid) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_SMP) begin
              cnt   <= '0;
              stg   <= '0;
              bfi   <= '0;
              state <= ST_TWID;
            end
          end
        end
        ST_TWID: begin
          if (tw_rsp_valid) begin
            w_c   <= tw_cos;
            w_s   <= tw_sin;
            state <= ST_BFLY;
          end
        end
        ST_BFLY: begin
          if (bfi == LAST_BF) begin
            bfi <= '0;
            if (stg == LAST_ST) begin
              cnt   <= '0;
              state <= ST_EMIT;
            end else begin
              stg   <= stg + 1'b1;
              state <= ST_TWID;
            end
          end else begin
            bfi   <= bfi + 1'b1;
            state <= ST_TWID;
          end
        end
        default: begin
          if (out_ready) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_SMP) begin
              cnt   <= '0;
              state <= ST_LOAD;
            end
          end
        end
      endcase
    end
  end

  // Sample store: bit-reversed load, in-place butterfly write-back
  always_ff @(posedge clk) begin
    if (state == ST_LOAD && in_valid) begin
      mem_re[load_addr] <= in_re;
      mem_im[load_addr] <= in_im;
    end else if (state == ST_BFLY) begin
      mem_re[idx_a] <= y0_re;
      mem_im[idx_a] <= y0_im;
      mem_re[idx_b] <= y1_re;
      mem_im[idx_b] <= y1_im;
    end
  end

  assign in_ready     = (state == ST_LOAD);
  assign tw_req_valid = (state == ST_TWID);
  assign tw_angle     = angle;
  assign out_valid    = (state == ST_EMIT);
  assign out_re       = mem_re[cnt];
  assign out_im       = mem_im[cnt];
  assign out_done     = (state == ST_EMIT) && (cnt == LAST_SMP);

  // R3
  twid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tw_req_valid && !tw_rsp_valid |=> tw_req_valid && $stable(tw_angle));

  // R3
  twid_range_chk: assert property (@(posedge clk) disable iff (rst)
    tw_req_valid |-> tw_angle < AW'(180));

  // R2
  ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !out_valid && !tw_req_valid);

  // R2
  load_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ready) |-> tw_req_valid);

  // R6
  emit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im) && $stable(out_done));

  // R7
  done_chk: assert property (@(posedge clk) disable iff (rst)
    out_done |-> out_valid);

endmodule

// File: tb/fft8_core_bench.sv
module fft8_core_bench;
  localparam int DW = 8;
  localparam int TW = 8;
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [DW-1:0] in_re = '0;
  logic signed [DW-1:0] in_im = '0;
  logic                 tw_req_valid;
  logic [AW-1:0]        tw_angle;
  logic                 tw_rsp_valid = 1'b0;
  logic signed [TW-1:0] tw_cos = '0;
  logic signed [TW-1:0] tw_sin = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b0;
  logic signed [DW-1:0] out_re;
  logic signed [DW-1:0] out_im;
  logic                 out_done;

  fft8_core u_fft8_core (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .tw_req_valid(tw_req_valid), .tw_angle(tw_angle),
    .tw_rsp_valid(tw_rsp_valid), .tw_cos(tw_cos), .tw_sin(tw_sin),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .out_done(out_done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Twiddle replies indexed by exponent (angle / 45)
  int tab_c [4];
  int tab_s [4];
  int exp_ang [12] = '{0, 0, 0, 0, 0, 90, 0, 90, 0, 45, 90, 135};
  int ang_idx = 0;
  int wait_cnt = 0;
  int dmul = 0;
  bit stray_en = 0;

  // Rotation-unit model
  always @(negedge clk) begin
    if (rst) begin
      tw_rsp_valid = 1'b0;
      wait_cnt = 0;
    end else if (tw_rsp_valid) begin
      tw_rsp_valid = 1'b0;
    end else if (tw_req_valid) begin
      if (wait_cnt > 0) begin
        wait_cnt--;
      end else begin
        int k;
        chk("R3", "twiddle angle", int'(tw_angle), exp_ang[ang_idx % 12]);
        k = int'(tw_angle) / 45;
        if (k > 3) k = 0;
        tw_cos = TW'(tab_c[k]);
        tw_sin = TW'(tab_s[k]);
        tw_rsp_valid = 1'b1;
        ang_idx++;
        wait_cnt = (ang_idx * dmul) % 4;
      end
    end else if (stray_en) begin
      // R9: reply with nothing pending
      tw_cos = TW'(-7);
      tw_sin = TW'(99);
      tw_rsp_valid = 1'b1;
    end
  end

  int fr_re [8], fr_im [8];
  int exp_re [8], exp_im [8];
  int got_re [8], got_im [8];

  function automatic int clip(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  // Reference transform following R4 and R5
  task automatic model();
    int ar [8], ai [8];
    for (int n = 0; n < 8; n++) begin
      int r;
      r = ((n & 1) << 2) | (n & 2) | ((n >> 2) & 1);
      ar[r] = fr_re[n];
      ai[r] = fr_im[n];
    end
    for (int s = 0; s < 3; s++) begin
      for (int b = 0; b < 4; b++) begin
        int h, j, ia, ib, e, c, sn, tr, ti, xr, xi;
        h  = 1 << s;
        j  = b % h;
        ia = (b / h) * 2 * h + j;
        ib = ia + h;
        e  = j << (2 - s);
        c  = tab_c[e];
        sn = tab_s[e];
        tr = (ar[ib] * c + ai[ib] * sn) >>> 6;
        ti = (ai[ib] * c - ar[ib] * sn) >>> 6;
        xr = ar[ia];
        xi = ai[ia];
        ar[ia] = clip((xr + tr) >>> 1);
        ai[ia] = clip((xi + ti) >>> 1);
        ar[ib] = clip((xr - tr) >>> 1);
        ai[ib] = clip((xi - ti) >>> 1);
      end
    end
    for (int k = 0; k < 8; k++) begin
      exp_re[k] = ar[k];
      exp_im[k] = ai[k];
    end
  endtask

  task automatic run_frame(input int rdy_mode, input int in_gap);
    int i, k, cyc;
    bit rdy;
    model();
    ang_idx = 0;
    i = 0;
    cyc = 0;
    while (i < 8) begin
      @(negedge clk);
      in_valid = (in_gap == 0) || ((cyc % 4) != 3);
      in_re = DW'(fr_re[i]);
      in_im = DW'(fr_im[i]);
      if (in_valid && in_ready) i++;
      cyc++;
    end
    // R8: junk offered during the transform and while bins drain
    k = 0;
    cyc = 0;
    while (k < 8) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_re = DW'(cyc * 37 - 100);
      in_im = DW'(55 - cyc * 13);
      rdy = (rdy_mode == 0) || (((cyc * rdy_mode) % 5) < 3);
      out_ready = rdy;
      if (out_valid && rdy) begin
        if (k == 0) chk("R2", "in_ready while emitting", int'(in_ready), 0);
        got_re[k] = int'(out_re);
        got_im[k] = int'(out_im);
        chk("R4 R5 R6 R8", $sformatf("bin %0d re", k), int'(out_re), exp_re[k]);
        chk("R4 R5 R6 R8", $sformatf("bin %0d im", k), int'(out_im), exp_im[k]);
        chk("R7", $sformatf("done at bin %0d", k), int'(out_done), (k == 7) ? 1 : 0);
        if (k == 7) in_valid = 1'b0;
        k++;
      end
      cyc++;
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk("R2", "in_ready after frame", int'(in_ready), 1);
    chk("R2", "out_valid after frame", int'(out_valid), 0);
    chk("R3", "twiddle requests per frame", ang_idx, 12);
  endtask

  task automatic nominal_tw();
    tab_c = '{64, 45, 0, -45};
    tab_s = '{0, 45, 64, 45};
  endtask

  bit [31:0] lf = 32'h1ACE_5EED;
  function automatic int rnd();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
    return int'(lf[7:0]) - 128;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "in_ready after reset", int'(in_ready), 1);
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "tw_req_valid after reset", int'(tw_req_valid), 0);
    chk("R1", "out_done after reset", int'(out_done), 0);

    nominal_tw();
    // Impulse: every bin equals 80/8
    for (int n = 0; n < 8; n++) begin fr_re[n] = (n == 0) ? 80 : 0; fr_im[n] = 0; end
    dmul = 0;
    run_frame(0, 0);
    for (int k = 0; k < 8; k++) begin
      chk("R4", $sformatf("impulse bin %0d re", k), got_re[k], 10);
      chk("R4", $sformatf("impulse bin %0d im", k), got_im[k], 0);
    end

    // Constant: only bin 0 carries energy
    for (int n = 0; n < 8; n++) begin fr_re[n] = 64; fr_im[n] = 0; end
    dmul = 1;
    run_frame(2, 1);
    chk("R4", "dc bin 0", got_re[0], 64);
    for (int k = 1; k < 8; k++) chk("R4", $sformatf("dc bin %0d re", k), got_re[k], 0);

    // Alternating sign: energy in bin 4
    for (int n = 0; n < 8; n++) begin fr_re[n] = (n % 2 == 0) ? 96 : -96; fr_im[n] = 0; end
    stray_en = 1;
    dmul = 3;
    run_frame(3, 1);
    chk("R4", "alternating bin 4", got_re[4], 96);

    // Negative full scale on both parts
    for (int n = 0; n < 8; n++) begin fr_re[n] = -128; fr_im[n] = -128; end
    run_frame(1, 0);

    // R5: inflated twiddles push stage sums past the rail
    tab_c = '{127, 127, 127, 127};
    tab_s = '{127, 127, 127, 127};
    for (int n = 0; n < 8; n++) begin fr_re[n] = 120 - n * 3; fr_im[n] = 100 - n * 20; end
    run_frame(2, 1);
    tab_c = '{-128, -128, 127, -128};
    tab_s = '{-128, 127, -128, 127};
    for (int n = 0; n < 8; n++) begin fr_re[n] = rnd(); fr_im[n] = rnd(); end
    run_frame(0, 0);

    // Pseudo-random sweep with varied latency and backpressure
    for (int f = 0; f < 24; f++) begin
      if (f % 5 == 4) begin
        for (int e = 0; e < 4; e++) begin tab_c[e] = rnd(); tab_s[e] = rnd(); end
      end else begin
        nominal_tw();
      end
      for (int n = 0; n < 8; n++) begin fr_re[n] = rnd(); fr_im[n] = rnd(); end
      dmul = f % 4;
      stray_en = (f % 2 == 1);
      run_frame(f % 4, f % 2);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog: actual timeout expected frame completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule